// File: doc/BRIEF.md
# Multi-Channel Reloadable Down-Counter Timer

This block is a memory-mapped timer with several identical 32-bit countdown channels. Software reaches it through a simple register port that carries an address, a write enable, an access-size code and write data, and returns registered read data. Each channel holds a reload value, a live counter and a 16-bit control word. A single byte-wide run register, shared by all channels, holds one run bit per channel.

A running channel divides the clock by a selectable prescale ratio and decrements its counter once per divided tick. When a tick finds the counter at zero, the channel loads the reload value back into the counter, latches an underflow flag and, if its interrupt enable is set, drives its own interrupt line. A reload of all ones gives the longest possible interval, which suits one-shot use. A reload of N gives a periodic event every N+1 ticks. Software derives an up-count by inverting the counter.

Top module: `tick_timer_bank`

## Requirements
- R1: After reset, the run register and every control word read zero. Every reload and counter register reads all ones. The interrupt lines and the read data are zero.
- R2: The run register is at byte address 0x00. Channel k occupies 0x04+12k (reload), 0x08+12k (counter) and 0x0C+12k (control). Read data appears on the clock edge that follows the address. Unmapped addresses read zero.
- R3: The size codes are 0 = byte, 1 = halfword and 2 = word. The run register takes only byte writes, the control word only halfword writes, and the reload and counter registers only word writes. A write of any other size changes nothing.
- R4: Bit k of the run register runs channel k. Bits at or above the channel count are not stored and read zero. While its run bit is clear, a channel's counter and prescaler hold their values.
- R5: Control bits 2:0 select a tick every 4, 16, 64, 256 or 1024 clocks for codes 0 to 4; any other code selects 4. The prescaler restarts from zero when the run bit rises, so the first decrement lands exactly one prescale period after the run-bit write.
- R6: A tick with the counter non-zero decrements it. A tick with the counter at zero loads the reload value and sets the underflow flag, which is control bit 8.
- R7: A control write with bit 8 at 0 clears the flag, and a write with bit 8 at 1 leaves it as it is. An underflow in the same cycle as a clearing write leaves the flag set.
- R8: Control bit 5 enables the interrupt. A channel's interrupt line is high exactly while both its flag and its enable are set.
- R9: A counter write takes effect in the cycle it is issued, even when the channel is running and a tick falls in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Byte address of the register access |
| wr_en | input | 1 | Write strobe |
| size | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| wdata | input | CNT_W | Write data, right-aligned |
| rdata | output | CNT_W | Registered read data for the previous cycle's address |
| irq | output | NUM_CH | Per-channel interrupt lines |

## Verification
The hardest case to reach is the prescaler restart. It only shows up when a channel is stopped partway through a prescale period and then started again. If the restart were missing, the leftover phase would make the tick come early. The bench stops a channel in the middle of a divide-by-64 period and reruns it. It then checks that the interrupt line stays low one clock before the full period and rises exactly on it. A second delicate case is a counter write on the very edge where a tick is due. The bench places that write by counting clocks from the run-bit write.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;

  localparam int CTRL_W    = 16;
  localparam int IE_BIT    = 5;
  localparam int FLAG_BIT  = 8;
  localparam int SEL_W     = 3;
  localparam int PRE_W     = 10;
  localparam int NUM_DIVS  = 5;

  // terminal count of the prescaler for a select code (ratio minus one)
  function automatic int pre_limit(input logic [SEL_W-1:0] code);
    if (int'(code) < NUM_DIVS) return (4 << (2 * int'(code))) - 1;
    return 3;
  endfunction
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
  import tmr_pkg::*;
#(
  parameter int PW = PRE_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             restart,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  logic [PW-1:0] phase_q;
  logic [PW-1:0] limit;
  logic          at_end;

  assign limit  = PW'(pre_limit(sel));
  assign at_end = (phase_q >= limit);
  assign tick   = run && at_end && !restart;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= '0;
    end else if (restart) begin
      phase_q <= '0;
    end else if (run) begin
      if (at_end) phase_q <= '0;
      else        phase_q <= phase_q + PW'(1);
    end
  end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int CW = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              restart,
  input  logic              wr_reload,
  input  logic              wr_count,
  input  logic              wr_ctrl,
  input  logic [CW-1:0]     wdata,
  output logic [CW-1:0]     reload_o,
  output logic [CW-1:0]     count_o,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic              tick_o,
  output logic              flag_o,
  output logic              ie_o,
  output logic              irq_o
);
  logic [CW-1:0]    reload_q;
  logic [CW-1:0]    count_q;
  logic [SEL_W-1:0] sel_q;
  logic             ie_q;
  logic             flag_q;
  logic             tick;
  logic             uflow;

  tmr_prescaler #(.PW(PRE_W)) u_pre (
    .clk     (clk),
    .rst     (rst),
    .run     (run),
    .restart (restart),
    .sel     (sel_q),
    .tick    (tick)
  );

  assign uflow = tick && (count_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      reload_q <= '1;
      count_q  <= '1;
      sel_q    <= '0;
      ie_q     <= 1'b0;
      flag_q   <= 1'b0;
    end else begin
      if (wr_reload) reload_q <= wdata;
      if (wr_count)   count_q <= wdata;
      else if (uflow) count_q <= reload_q;
      else if (tick)  count_q <= count_q - CW'(1);
      if (wr_ctrl) begin
        sel_q <= wdata[SEL_W-1:0];
        ie_q  <= wdata[IE_BIT];
      end
      if (uflow)                          flag_q <= 1'b1;
      else if (wr_ctrl && !wdata[FLAG_BIT]) flag_q <= 1'b0;
    end
  end

  always_comb begin
    ctrl_o             = '0;
    ctrl_o[SEL_W-1:0]  = sel_q;
    ctrl_o[IE_BIT]     = ie_q;
    ctrl_o[FLAG_BIT]   = flag_q;
  end

  assign reload_o = reload_q;
  assign count_o  = count_q;
  assign tick_o   = tick;
  assign flag_o   = flag_q;
  assign ie_o     = ie_q;
  assign irq_o    = flag_q & ie_q;
endmodule

// File: rtl/tick_timer_bank.sv
module tick_timer_bank
  import tmr_pkg::*;
#(
  parameter int NUM_CH  = 3,
  parameter int CNT_W   = 32,
  parameter int ADDR_W  = 6,
  parameter int START_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [1:0]        size,
  input  logic [CNT_W-1:0]  wdata,
  output logic [CNT_W-1:0]  rdata,
  output logic [NUM_CH-1:0] irq
);
  localparam int CH_BASE    = 4;
  localparam int CH_STRIDE  = 12;
  localparam int OFS_RELOAD = 0;
  localparam int OFS_COUNT  = 4;
  localparam int OFS_CTRL   = 8;
  localparam logic [ADDR_W-1:0] RUN_ADDR = '0;

  logic                          wr_byte, wr_half, wr_word;
  logic                          wr_run;
  logic [NUM_CH-1:0]             run_q;
  logic [NUM_CH-1:0]             restart;
  logic [NUM_CH-1:0]             ch_wr_reload, ch_wr_count, ch_wr_ctrl;
  logic [NUM_CH-1:0]             ch_hit, ch_tick, ch_flag, ch_ie;
  logic [NUM_CH-1:0][CNT_W-1:0]  ch_reload, ch_count, ch_rd;
  logic [NUM_CH-1:0][CTRL_W-1:0] ch_ctrl;
  logic [CNT_W-1:0]              rd_mux;

  assign wr_byte = wr_en && (size == SZ_BYTE);
  assign wr_half = wr_en && (size == SZ_HALF);
  assign wr_word = wr_en && (size == SZ_WORD);
  assign wr_run  = wr_byte && (addr == RUN_ADDR);

  // restart a prescaler only on a stopped-to-running transition
  assign restart = {NUM_CH{wr_run}} & wdata[NUM_CH-1:0] & ~run_q;

  always_ff @(posedge clk) begin
    if (rst)         run_q <= '0;
    else if (wr_run) run_q <= wdata[NUM_CH-1:0];
  end

  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
    localparam logic [ADDR_W-1:0] A_RL = ADDR_W'(CH_BASE + k*CH_STRIDE + OFS_RELOAD);
    localparam logic [ADDR_W-1:0] A_CN = ADDR_W'(CH_BASE + k*CH_STRIDE + OFS_COUNT);
    localparam logic [ADDR_W-1:0] A_CT = ADDR_W'(CH_BASE + k*CH_STRIDE + OFS_CTRL);

    assign ch_wr_reload[k] = wr_word && (addr == A_RL);
    assign ch_wr_count[k]  = wr_word && (addr == A_CN);
    assign ch_wr_ctrl[k]   = wr_half && (addr == A_CT);
    assign ch_hit[k]       = (addr == A_RL) || (addr == A_CN) || (addr == A_CT);
    assign ch_rd[k]        = (addr == A_RL) ? ch_reload[k] :
                             (addr == A_CN) ? ch_count[k]  : CNT_W'(ch_ctrl[k]);

    tmr_channel #(.CW(CNT_W)) u_ch (
      .clk       (clk),
      .rst       (rst),
      .run       (run_q[k]),
      .restart   (restart[k]),
      .wr_reload (ch_wr_reload[k]),
      .wr_count  (ch_wr_count[k]),
      .wr_ctrl   (ch_wr_ctrl[k]),
      .wdata     (wdata),
      .reload_o  (ch_reload[k]),
      .count_o   (ch_count[k]),
      .ctrl_o    (ch_ctrl[k]),
      .tick_o    (ch_tick[k]),
      .flag_o    (ch_flag[k]),
      .ie_o      (ch_ie[k]),
      .irq_o     (irq[k])
    );
  end

  always_comb begin
    rd_mux = '0;
    if (addr == RUN_ADDR) rd_mux = CNT_W'(run_q);
    for (int k = 0; k < NUM_CH; k++) begin
      if (ch_hit[k]) rd_mux = ch_rd[k];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_mux;
  end
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
  parameter int NUM_CH = 3,
  parameter int CW     = 32
) (
  input logic                       clk,
  input logic                       rst,
  input logic [NUM_CH-1:0]          run,
  input logic [NUM_CH-1:0]          tick,
  input logic [NUM_CH-1:0][CW-1:0]  count,
  input logic [NUM_CH-1:0][CW-1:0]  reload,
  input logic [NUM_CH-1:0]          wr_count,
  input logic [NUM_CH-1:0]          wr_ctrl,
  input logic [NUM_CH-1:0]          flag,
  input logic [NUM_CH-1:0]          ie,
  input logic [NUM_CH-1:0]          irq
);
  for (genvar k = 0; k < NUM_CH; k++) begin : g_chk
    assert_reset_R1: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (count[k] == '1) && !run[k] && !flag[k] && !irq[k]);

    assert_frozen_R4: assert property (@(posedge clk) disable iff (rst)
      (!run[k] && !wr_count[k]) |=> $stable(count[k]));

    assert_tick_gated_R5: assert property (@(posedge clk) disable iff (rst)
      tick[k] |-> run[k]);

    assert_decrement_R6: assert property (@(posedge clk) disable iff (rst)
      (tick[k] && count[k] != '0 && !wr_count[k]) |=> count[k] == $past(count[k]) - CW'(1));

    assert_reload_R6: assert property (@(posedge clk) disable iff (rst)
      (tick[k] && count[k] == '0 && !wr_count[k]) |=> (count[k] == $past(reload[k])) && flag[k]);

    assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (rst)
      (flag[k] && !wr_ctrl[k]) |=> flag[k]);

    assert_irq_rise_R8: assert property (@(posedge clk) disable iff (rst)
      (tick[k] && count[k] == '0 && ie[k] && !wr_ctrl[k]) |=> irq[k]);
  end
endmodule

bind tick_timer_bank tmr_checker #(.NUM_CH(NUM_CH), .CW(CNT_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .run      (run_q),
  .tick     (ch_tick),
  .count    (ch_count),
  .reload   (ch_reload),
  .wr_count (ch_wr_count),
  .wr_ctrl  (ch_wr_ctrl),
  .flag     (ch_flag),
  .ie       (ch_ie),
  .irq      (irq)
);

// File: tb/tick_timer_bank_test.sv
module tick_timer_bank_test;
  localparam int NUM_CH = 3;
  localparam int CNT_W  = 32;
  localparam int ADDR_W = 6;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [ADDR_W-1:0] addr = '0;
  logic              wr_en = 1'b0;
  logic [1:0]        size = 2'd0;
  logic [CNT_W-1:0]  wdata = '0;
  logic [CNT_W-1:0]  rdata;
  logic [NUM_CH-1:0] irq;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  bit arm    = 1'b0;
  logic [CNT_W-1:0] exp_q[$];
  string            tag_q[$];

  always #2 clk = ~clk;

  tick_timer_bank #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) uut (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .size(size),
    .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  // drive at a falling edge; the write lands on the next rising edge
  task automatic wr(input logic [ADDR_W-1:0] a, input logic [1:0] s, input logic [CNT_W-1:0] d);
    addr = a; size = s; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // driver: queue the expected read value, the monitor compares it
  task automatic rd_check(input logic [ADDR_W-1:0] a, input logic [CNT_W-1:0] e, input string tag);
    addr = a; wr_en = 1'b0;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    arm = 1'b1;
    @(negedge clk);
  endtask

  task automatic check_val(input logic [CNT_W-1:0] act, input logic [CNT_W-1:0] e, input string tag);
    checks++;
    if (act !== e) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, e);
    end
  endtask

  // monitor: pops one expectation per armed read, after the capture edge
  initial begin
    forever begin
      @(posedge clk);
      if (arm) begin
        arm = 1'b0;
        #1;
        check_val(rdata, exp_q.pop_front(), tag_q.pop_front());
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    check_val(rdata, 32'h0, "R1 rdata after reset");
    check_val(CNT_W'(irq), 32'h0, "R1 irq after reset");
    rd_check(6'h00, 32'h0, "R1 run register reset");
    rd_check(6'h04, 32'hFFFF_FFFF, "R1 ch0 reload reset");
    rd_check(6'h08, 32'hFFFF_FFFF, "R1 ch0 counter reset");
    rd_check(6'h24, 32'h0, "R1 ch2 control reset");
    rd_check(6'h3C, 32'h0, "R2 unmapped reads zero");

    // wrong-size writes are ignored
    wr(6'h08, 2'd0, 32'h5);
    rd_check(6'h08, 32'hFFFF_FFFF, "R3 byte write to counter ignored");
    wr(6'h0C, 2'd2, 32'h20);
    rd_check(6'h0C, 32'h0, "R3 word write to control ignored");
    wr(6'h00, 2'd1, 32'h1);
    rd_check(6'h00, 32'h0, "R3 halfword write to run ignored");

    // channel 0: divide by 4, counter 2, reload 3, interrupt on
    wr(6'h04, 2'd2, 32'd3);
    wr(6'h08, 2'd2, 32'd2);
    wr(6'h0C, 2'd1, 32'h0020);
    wr(6'h00, 2'd0, 32'h01);              // edge E0
    repeat (11) @(negedge clk);
    check_val(CNT_W'(irq[0]), 32'h0, "R6 ch0 no underflow before third tick");
    @(negedge clk);
    check_val(CNT_W'(irq[0]), 32'h1, "R8 ch0 irq on underflow");
    check_val(CNT_W'(irq[2:1]), 32'h0, "R8 other channels quiet");
    wr(6'h00, 2'd0, 32'h00);              // stop at E0+13
    rd_check(6'h08, 32'd3, "R6 ch0 counter reloaded");
    rd_check(6'h0C, 32'h0120, "R6 ch0 flag set in control");
    wr(6'h0C, 2'd1, 32'h0120);
    rd_check(6'h0C, 32'h0120, "R7 write of one keeps flag");
    wr(6'h0C, 2'd1, 32'h0020);
    check_val(CNT_W'(irq[0]), 32'h0, "R7 flag cleared drops irq");
    rd_check(6'h0C, 32'h0020, "R7 flag cleared");
    repeat (20) @(negedge clk);
    rd_check(6'h08, 32'd3, "R4 stopped counter frozen");

    // channel 1: divide by 64, counter 1, interrupt off
    wr(6'h10, 2'd2, 32'hFFFF_FFFF);
    wr(6'h14, 2'd2, 32'd1);
    wr(6'h18, 2'd1, 32'h0002);
    wr(6'h00, 2'd0, 32'h02);              // edge E1
    repeat (99) @(negedge clk);
    wr(6'h00, 2'd0, 32'h00);              // stop at E1+100, mid-period
    rd_check(6'h14, 32'd0, "R5 ch1 one tick after 64 clocks");
    wr(6'h18, 2'd1, 32'h0022);
    wr(6'h00, 2'd0, 32'h02);              // edge E2, prescaler restarts
    repeat (63) @(negedge clk);
    check_val(CNT_W'(irq[1]), 32'h0, "R5 ch1 no tick before full period after restart");
    @(negedge clk);
    check_val(CNT_W'(irq[1]), 32'h1, "R5 ch1 tick exactly one period after restart");
    wr(6'h00, 2'd0, 32'h00);
    rd_check(6'h14, 32'hFFFF_FFFF, "R6 ch1 reload of all ones");
    wr(6'h18, 2'd1, 32'h0102);
    check_val(CNT_W'(irq[1]), 32'h0, "R8 flag without enable gives no irq");
    rd_check(6'h18, 32'h0102, "R8 flag kept with enable off");

    // channel 2: undefined select code acts as divide by 4
    wr(6'h1C, 2'd2, 32'd7);
    wr(6'h20, 2'd2, 32'd0);
    wr(6'h24, 2'd1, 32'h0025);
    wr(6'h00, 2'd0, 32'h04);              // edge E3
    repeat (3) @(negedge clk);
    check_val(CNT_W'(irq[2]), 32'h0, "R5 ch2 code 5 no tick before 4 clocks");
    @(negedge clk);
    check_val(CNT_W'(irq[2]), 32'h1, "R5 ch2 code 5 ticks after 4 clocks");
    repeat (3) @(negedge clk);
    wr(6'h20, 2'd2, 32'd100);             // lands on tick edge E3+8
    wr(6'h00, 2'd0, 32'h00);
    rd_check(6'h20, 32'd100, "R9 counter write wins over tick");
    rd_check(6'h1C, 32'd7, "R2 ch2 reload readback");

    wr(6'h00, 2'd0, 32'hF8);
    rd_check(6'h00, 32'h0, "R4 upper run bits not stored");
    rd_check(6'h08, 32'd3, "R4 ch0 still frozen");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule